// File: doc/BRIEF.md
# Serial Audio Input Router with Loopback

This block chooses which serial audio stream feeds a stereo DAC data path and turns it into 24-bit left/right sample pairs. The source is one of two external serial data lines or, in loopback, the ADC sample pair that the block itself is shifting out. The bit clock and word clock are shared with the ADC side and arrive as levels synchronous to the system clock. Each word-clock frame has two 32-bit slots: word clock low is the left slot, high is the right slot. The DAC side decodes a slot by one of four formats. The ADC side encodes by one of two formats onto a serial data output.

Settings come in through a small write-only register port. Source, loopback and DAC format take effect only at a frame start, so no output pair ever mixes two settings. While loopback is active the DAC format setting is frozen. A value written meanwhile waits and is applied at the frame start where loopback ends. A clocking-change pulse forces a fixed number of zero pairs out.

Top module: `audin_router`

## Requirements
- R1: During and after reset, before any frame boundary, `dac_valid` is 0, `dac_left`/`dac_right` are zero and `sdout` is 0.
- R2: Address 1 bit 0 selects the external input: 0 takes `sdin_a`, 1 takes `sdin_b`; the unselected line has no effect on the output pairs.
- R3: Input bits are sampled on rising `sclk`; slot bit 0 is the first bit after a `lrck` change. The DAC format is at address 0 bits [1:0]. Code 00: the word is slot bits 0..23, MSB first. Code 01: bits 1..24. Code 10: the last 16 bits, given as {word16, 8'h00}. Code 11: the last 24 bits.
- R4: With loopback on (address 1 bit 1), each output pair equals the ADC pair that was serialized during the frame that just ended, and both external inputs are ignored.
- R5: A DAC-format write made while loopback is active changes nothing while loopback lasts. The most recent such value is applied to the first frame that starts with loopback off.
- R6: Source, loopback and DAC-format writes take effect at the next frame start: a rising `sclk` that sees `lrck` go from 1 to 0. A frame already in progress finishes with the old settings.
- R7: `sdout` changes after falling `sclk`. The ADC pair is taken from `adc_left`/`adc_right` at the falling edge that opens the left slot. The ADC format is address 1 bit 2: 0 places the word at slot bits 0..23, 1 at bits 1..24. All other slot bits are 0. This also holds during loopback.
- R8: `dac_valid` pulses for one cycle two clocks after each frame-start `sclk` edge is seen. It carries the pair of the frame that just ended. Outside loopback that pair is zero unless both slots held exactly 32 bits.
- R9: A one-cycle `clk_chg` pulse forces the next MUTE_FRAMES output pairs to zero.
- R10: An ADC-format write takes effect at the next left-slot start on `sdout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register address (0: DAC format, 1: routing) |
| reg_wdata | input | 8 | Register write data |
| clk_chg | input | 1 | Clocking-mode change pulse |
| sclk | input | 1 | Serial bit clock level |
| lrck | input | 1 | Word clock level (low = left) |
| sdin_a | input | 1 | External serial data input A |
| sdin_b | input | 1 | External serial data input B |
| adc_left | input | 24 | ADC left sample to serialize |
| adc_right | input | 24 | ADC right sample to serialize |
| dac_left | output | 24 | Left sample to the DAC path |
| dac_right | output | 24 | Right sample to the DAC path |
| dac_valid | output | 1 | New sample pair strobe |
| sdout | output | 1 | Serial ADC data output |

## Verification
The assertions assume well-formed framing. No slot carries more than 32 bits. `sclk` stays at each level for several system clocks. `clk_chg` never coincides with a frame-start edge. The stimulus holds each `sclk` phase for four clocks. It changes `lrck` and data only together with a falling `sclk` edge. It issues register writes and the clock-change pulse between bit edges. The only deliberately short slot is shorter, not longer, which stays within the slot-length assumption.

// File: rtl/air_pkg.sv
package air_pkg;
  typedef enum logic [1:0] {
    DF_LJ24  = 2'b00,
    DF_I2S24 = 2'b01,
    DF_RJ16  = 2'b10,
    DF_RJ24  = 2'b11
  } dac_fmt_e;

  localparam logic ADDR_DAC_FMT = 1'b0;
  localparam logic ADDR_ROUTE   = 1'b1;
  localparam int   RT_SRC_BIT   = 0;
  localparam int   RT_LOOP_BIT  = 1;
  localparam int   RT_ADCF_BIT  = 2;
endpackage

// File: rtl/air_edge.sv
module air_edge (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  input  logic lrck,
  input  logic sdin_a,
  input  logic sdin_b,
  output logic rise,
  output logic fall,
  output logic lrck_lvl,
  output logic bit_a,
  output logic bit_b,
  output logic slot_chg,
  output logic frame_bnd
);
  logic sclk_q1, sclk_q2, lrck_q1, a_q1, b_q1, lrck_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q1   <= 1'b1;
      sclk_q2   <= 1'b1;
      lrck_q1   <= 1'b1;
      a_q1      <= 1'b0;
      b_q1      <= 1'b0;
      lrck_seen <= 1'b1;
    end else begin
      sclk_q1 <= sclk;
      sclk_q2 <= sclk_q1;
      lrck_q1 <= lrck;
      a_q1    <= sdin_a;
      b_q1    <= sdin_b;
      if (rise) lrck_seen <= lrck_q1;
    end
  end

  always_comb begin
    rise      = sclk_q1 & ~sclk_q2;
    fall      = ~sclk_q1 & sclk_q2;
    lrck_lvl  = lrck_q1;
    bit_a     = a_q1;
    bit_b     = b_q1;
    slot_chg  = rise && (lrck_q1 != lrck_seen);
    frame_bnd = slot_chg && !lrck_q1;
  end
endmodule

// File: rtl/air_deser.sv
module air_deser #(
  parameter int SLOT_BITS  = 32,
  parameter int WORD_BITS  = 24,
  parameter int SHORT_BITS = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rise,
  input  logic                 slot_chg,
  input  logic                 lrck_lvl,
  input  logic                 bit_in,
  input  air_pkg::dac_fmt_e    fmt,
  output logic [WORD_BITS-1:0] word_now,
  output logic                 slot_full,
  output logic [WORD_BITS-1:0] left_word,
  output logic                 left_ok
);
  import air_pkg::*;
  localparam int CNT_W = $clog2(SLOT_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(SLOT_BITS);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(SLOT_BITS + 1);
  localparam int PAD_BITS = WORD_BITS - SHORT_BITS;

  logic [SLOT_BITS-1:0] shreg;
  logic [CNT_W-1:0]     cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg     <= '0;
      cnt       <= '0;
      left_word <= '0;
      left_ok   <= 1'b0;
    end else if (rise) begin
      if (slot_chg) begin
        if (lrck_lvl) begin
          left_word <= word_now;
          left_ok   <= slot_full;
        end else begin
          left_ok <= 1'b0;
        end
        shreg <= {{(SLOT_BITS-1){1'b0}}, bit_in};
        cnt   <= CNT_W'(1);
      end else begin
        shreg <= {shreg[SLOT_BITS-2:0], bit_in};
        if (cnt != CNT_OVER) cnt <= cnt + 1'b1;
      end
    end
  end

  always_comb begin
    slot_full = (cnt == CNT_FULL);
    unique case (fmt)
      DF_LJ24:  word_now = shreg[SLOT_BITS-1 -: WORD_BITS];
      DF_I2S24: word_now = shreg[SLOT_BITS-2 -: WORD_BITS];
      DF_RJ16:  word_now = {shreg[SHORT_BITS-1:0], {PAD_BITS{1'b0}}};
      default:  word_now = shreg[WORD_BITS-1:0];
    endcase
  end

  AST_SLOT_LEN: assert property (@(posedge clk) disable iff (rst)
    (rise && !slot_chg) |-> (cnt < CNT_FULL)); // R3
endmodule

// File: rtl/air_ser.sv
module air_ser #(
  parameter int SLOT_BITS = 32,
  parameter int WORD_BITS = 24
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fall,
  input  logic                 lrck_lvl,
  input  logic [WORD_BITS-1:0] adc_l,
  input  logic [WORD_BITS-1:0] adc_r,
  input  logic                 fmt_req,
  output logic                 sdout,
  output logic [WORD_BITS-1:0] sent_l,
  output logic [WORD_BITS-1:0] sent_r
);
  localparam int POS_W = $clog2(SLOT_BITS);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(SLOT_BITS - 1);
  localparam logic [POS_W-1:0] POS_WB   = POS_W'(WORD_BITS);

  logic [WORD_BITS-1:0] cur_l, cur_r, word, shifted;
  logic [POS_W-1:0]     pos, pos_n, sh;
  logic                 prev_lr, fmt_lat, fmt_use, new_slot, new_left, in_rng, bit_n;

  always_comb begin
    new_slot = (lrck_lvl != prev_lr);
    new_left = new_slot && !lrck_lvl;
    if (new_slot)           pos_n = '0;
    else if (pos == POS_LAST) pos_n = pos;
    else                    pos_n = pos + 1'b1;
    fmt_use = new_left ? fmt_req : fmt_lat;
    if (new_left)      word = adc_l;
    else if (lrck_lvl) word = cur_r;
    else               word = cur_l;
    in_rng  = fmt_use ? (pos_n != '0 && pos_n <= POS_WB) : (pos_n < POS_WB);
    sh      = fmt_use ? pos_n - 1'b1 : pos_n;
    shifted = word << sh;
    bit_n   = in_rng && shifted[WORD_BITS-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos     <= '0;
      prev_lr <= 1'b1;
      fmt_lat <= 1'b0;
      cur_l   <= '0;
      cur_r   <= '0;
      sent_l  <= '0;
      sent_r  <= '0;
      sdout   <= 1'b0;
    end else if (fall) begin
      pos     <= pos_n;
      prev_lr <= lrck_lvl;
      sdout   <= bit_n;
      if (new_left) begin
        sent_l  <= cur_l;
        sent_r  <= cur_r;
        cur_l   <= adc_l;
        cur_r   <= adc_r;
        fmt_lat <= fmt_req;
      end
    end
  end

  AST_SDOUT_TAIL: assert property (@(posedge clk) disable iff (rst)
    (fall && !new_slot && pos >= POS_W'(WORD_BITS + 1)) |=> !sdout); // R7
endmodule

// File: rtl/air_ctrl.sv
module air_ctrl (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic              reg_addr,
  input  logic [7:0]        reg_wdata,
  input  logic              frame_bnd,
  output logic              req_src,
  output logic              req_adc_fmt,
  output logic              act_src,
  output logic              act_loop,
  output air_pkg::dac_fmt_e act_fmt
);
  import air_pkg::*;
  logic     req_loop;
  dac_fmt_e req_fmt;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_src     <= 1'b0;
      req_loop    <= 1'b0;
      req_adc_fmt <= 1'b0;
      req_fmt     <= DF_LJ24;
      act_src     <= 1'b0;
      act_loop    <= 1'b0;
      act_fmt     <= DF_LJ24;
    end else begin
      if (reg_we && reg_addr == ADDR_DAC_FMT) req_fmt <= dac_fmt_e'(reg_wdata[1:0]);
      if (reg_we && reg_addr == ADDR_ROUTE) begin
        req_src     <= reg_wdata[RT_SRC_BIT];
        req_loop    <= reg_wdata[RT_LOOP_BIT];
        req_adc_fmt <= reg_wdata[RT_ADCF_BIT];
      end
      if (frame_bnd) begin
        act_src  <= req_src;
        act_loop <= req_loop;
        if (!req_loop) act_fmt <= req_fmt;
      end
    end
  end

  AST_FMT_HOLD_LOOP: assert property (@(posedge clk) disable iff (rst)
    (act_loop && req_loop) |=> $stable(act_fmt)); // R5
  AST_CFG_AT_BND: assert property (@(posedge clk) disable iff (rst)
    !frame_bnd |=> ($stable(act_src) && $stable(act_loop) && $stable(act_fmt))); // R6
endmodule

// File: rtl/audin_router.sv
module audin_router #(
  parameter int SLOT_BITS   = 32,
  parameter int WORD_BITS   = 24,
  parameter int SHORT_BITS  = 16,
  parameter int MUTE_FRAMES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_we,
  input  logic                 reg_addr,
  input  logic [7:0]           reg_wdata,
  input  logic                 clk_chg,
  input  logic                 sclk,
  input  logic                 lrck,
  input  logic                 sdin_a,
  input  logic                 sdin_b,
  input  logic [WORD_BITS-1:0] adc_left,
  input  logic [WORD_BITS-1:0] adc_right,
  output logic [WORD_BITS-1:0] dac_left,
  output logic [WORD_BITS-1:0] dac_right,
  output logic                 dac_valid,
  output logic                 sdout
);
  import air_pkg::*;
  localparam int MUTE_W = $clog2(MUTE_FRAMES + 1);
  localparam logic [MUTE_W-1:0] MUTE_LOAD = MUTE_W'(MUTE_FRAMES);

  logic rise, fall, lrck_lvl, bit_a, bit_b, slot_chg, frame_bnd;
  logic req_src, req_adc_fmt, act_src, act_loop, src_eff, bit_in, slot_full, left_ok;
  dac_fmt_e act_fmt;
  logic [WORD_BITS-1:0] word_now, left_word, sent_l, sent_r;
  logic [MUTE_W-1:0]    mute_cnt;

  air_edge u_edge (
    .clk(clk), .rst(rst), .sclk(sclk), .lrck(lrck), .sdin_a(sdin_a), .sdin_b(sdin_b),
    .rise(rise), .fall(fall), .lrck_lvl(lrck_lvl), .bit_a(bit_a), .bit_b(bit_b),
    .slot_chg(slot_chg), .frame_bnd(frame_bnd)
  );

  air_ctrl u_ctrl (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .frame_bnd(frame_bnd), .req_src(req_src), .req_adc_fmt(req_adc_fmt),
    .act_src(act_src), .act_loop(act_loop), .act_fmt(act_fmt)
  );

  // the first bit of a new frame already belongs to the newly requested source
  always_comb begin
    src_eff = frame_bnd ? req_src : act_src;
    bit_in  = src_eff ? bit_b : bit_a;
  end

  air_deser #(.SLOT_BITS(SLOT_BITS), .WORD_BITS(WORD_BITS), .SHORT_BITS(SHORT_BITS)) u_deser (
    .clk(clk), .rst(rst), .rise(rise), .slot_chg(slot_chg), .lrck_lvl(lrck_lvl),
    .bit_in(bit_in), .fmt(act_fmt), .word_now(word_now), .slot_full(slot_full),
    .left_word(left_word), .left_ok(left_ok)
  );

  air_ser #(.SLOT_BITS(SLOT_BITS), .WORD_BITS(WORD_BITS)) u_ser (
    .clk(clk), .rst(rst), .fall(fall), .lrck_lvl(lrck_lvl), .adc_l(adc_left),
    .adc_r(adc_right), .fmt_req(req_adc_fmt), .sdout(sdout), .sent_l(sent_l), .sent_r(sent_r)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dac_left  <= '0;
      dac_right <= '0;
      dac_valid <= 1'b0;
      mute_cnt  <= '0;
    end else begin
      dac_valid <= frame_bnd;
      if (frame_bnd) begin
        if (mute_cnt != '0) begin
          dac_left  <= '0;
          dac_right <= '0;
        end else if (act_loop) begin
          dac_left  <= sent_l;
          dac_right <= sent_r;
        end else if (left_ok && slot_full) begin
          dac_left  <= left_word;
          dac_right <= word_now;
        end else begin
          dac_left  <= '0;
          dac_right <= '0;
        end
      end
      if (clk_chg)                          mute_cnt <= MUTE_LOAD;
      else if (frame_bnd && mute_cnt != '0) mute_cnt <= mute_cnt - 1'b1;
    end
  end

  AST_MUTE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (frame_bnd && mute_cnt != '0) |=> (dac_valid && dac_left == '0 && dac_right == '0)); // R9
  AST_LOOP_PASS: assert property (@(posedge clk) disable iff (rst)
    (frame_bnd && mute_cnt == '0 && act_loop) |=>
      (dac_left == $past(sent_l) && dac_right == $past(sent_r))); // R4
endmodule

// File: tb/tb_audin_router.sv
module tb_audin_router;
  localparam int MUTE_N = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0, reg_addr = 1'b0, clk_chg = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic        sclk = 1'b1, lrck = 1'b1, sdin_a = 1'b0, sdin_b = 1'b0;
  logic [23:0] adc_left = '0, adc_right = '0;
  logic [23:0] dac_left, dac_right;
  logic        dac_valid, sdout;

  int n_tests = 0, n_fail = 0;

  audin_router #(.MUTE_FRAMES(MUTE_N)) dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .clk_chg(clk_chg), .sclk(sclk), .lrck(lrck), .sdin_a(sdin_a), .sdin_b(sdin_b),
    .adc_left(adc_left), .adc_right(adc_right), .dac_left(dac_left), .dac_right(dac_right),
    .dac_valid(dac_valid), .sdout(sdout)
  );

  always #2.5 clk = ~clk;

  // reference model state
  logic [1:0]  m_req_fmt = 2'b00, m_act_fmt = 2'b00;
  logic        m_req_src = 0, m_req_loop = 0, m_req_adc = 0;
  logic        m_act_src = 0, m_act_loop = 0;
  logic [47:0] prev_pair = '0, prev_adc = '0;
  logic        prev_ok = 0, prev_loop = 0;
  string       prev_tag = "R8";
  int          m_mute = 0;
  logic [47:0] expq[$];
  string       tagq[$];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    if (a == 1'b0) m_req_fmt = d[1:0];
    else begin
      m_req_src = d[0]; m_req_loop = d[1]; m_req_adc = d[2];
    end
  endtask

  function automatic logic [31:0] enc(input logic [23:0] w, input logic [1:0] f, input logic [31:0] j);
    case (f)
      2'b00:   return {w, j[7:0]};
      2'b01:   return {j[0], w, j[6:0]};
      2'b10:   return {j[15:0], w[23:8]};
      default: return {j[7:0], w};
    endcase
  endfunction

  function automatic logic [23:0] dec(input logic [31:0] s, input logic [1:0] f);
    case (f)
      2'b00:   return s[31:8];
      2'b01:   return s[30:7];
      2'b10:   return {s[15:0], 8'h00};
      default: return s[23:0];
    endcase
  endfunction

  function automatic logic [31:0] adc_slot(input logic [23:0] w, input logic f);
    return f ? {1'b0, w, 7'h00} : {w, 8'h00};
  endfunction

  task automatic boundary();
    if (m_mute > 0) begin
      expq.push_back('0); tagq.push_back("R9"); m_mute--;
    end else if (prev_loop) begin
      expq.push_back(prev_adc); tagq.push_back(prev_tag);
    end else begin
      expq.push_back(prev_ok ? prev_pair : 48'h0); tagq.push_back(prev_ok ? prev_tag : "R8");
    end
  endtask

  task automatic send_frame(input logic [23:0] al, ar, bl, br, input logic [1:0] txf,
                            input logic [23:0] xl, xr, input string tag,
                            input int lbits = 32, input bit mw = 0, input logic ma = 0,
                            input logic [7:0] md = 0);
    logic [31:0] sal, sar, sbl, sbr, obs_l, obs_r;
    logic adcf;
    obs_l = '0; obs_r = '0;
    sal = enc(al, txf, 32'h5A3C_96E1 ^ {ar[7:0], al[23:0]});
    sar = enc(ar, txf, 32'hC3A5_1E69 ^ {al[7:0], ar[23:0]});
    sbl = enc(bl, txf, 32'h0F1E_2D3C);
    sbr = enc(br, txf, 32'hF0E1_D2C3);
    adc_left = xl; adc_right = xr;
    boundary();
    m_act_src = m_req_src; m_act_loop = m_req_loop;
    if (!m_req_loop) m_act_fmt = m_req_fmt;
    adcf = m_req_adc;
    prev_pair = m_act_src ? {dec(sbl, m_act_fmt), dec(sbr, m_act_fmt)}
                          : {dec(sal, m_act_fmt), dec(sar, m_act_fmt)};
    prev_ok = (lbits == 32); prev_loop = m_act_loop; prev_adc = {xl, xr}; prev_tag = tag;
    for (int i = 0; i < lbits; i++) begin
      sclk = 1'b0; lrck = 1'b0; sdin_a = sal[31-i]; sdin_b = sbl[31-i];
      tick(4);
      sclk = 1'b1; obs_l[31-i] = sdout;
      tick(4);
    end
    for (int i = 0; i < 32; i++) begin
      sclk = 1'b0; lrck = 1'b1; sdin_a = sar[31-i]; sdin_b = sbr[31-i];
      tick(4);
      sclk = 1'b1; obs_r[31-i] = sdout;
      if (mw && i == 8) wr(ma, md);
      tick(4);
    end
    if (lbits == 32)
      chk(obs_l == adc_slot(xl, adcf), adcf ? "R10 sdout left" : "R7 sdout left",
          64'(obs_l), 64'(adc_slot(xl, adcf)));
    chk(obs_r == adc_slot(xr, adcf), adcf ? "R10 sdout right" : "R7 sdout right",
        64'(obs_r), 64'(adc_slot(xr, adcf)));
  endtask

  // compares the DAC strobe and pair against the model on every clock
  always @(negedge clk) begin
    if (!rst && dac_valid) begin
      if (expq.size() == 0) chk(1'b0, "R8 unexpected dac_valid", 64'(1), 64'(0));
      else begin
        logic [47:0] e;
        string t;
        e = expq.pop_front(); t = tagq.pop_front();
        chk({dac_left, dac_right} == e, t, 64'({dac_left, dac_right}), 64'(e));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 64'(0), 64'(1));
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    tick(5);
    chk(dac_valid == 1'b0 && dac_left == '0 && dac_right == '0 && sdout == 1'b0,
        "R1 reset outputs", 64'({dac_valid, dac_left, dac_right, sdout}), 64'(0));
    rst = 1'b0;
    tick(5);
    chk(dac_valid == 1'b0 && dac_left == '0 && sdout == 1'b0,
        "R1 idle after reset", 64'({dac_valid, dac_left, sdout}), 64'(0));
    // formats on input A (R3), writes between frames apply at frame start (R6)
    send_frame(24'h123456, 24'hABCDEF, 24'h777777, 24'h888888, 2'b00, 24'h800001, 24'h7FFFFE, "R3 LJ24");
    wr(0, 8'h01);
    send_frame(24'hFEDCBA, 24'h0F0F0F, 24'h111111, 24'h222222, 2'b01, 24'h13579B, 24'h2468AC, "R3 I2S24");
    wr(0, 8'h02);
    send_frame(24'hA5A5A5, 24'h5A5A5A, 24'h333333, 24'h444444, 2'b10, 24'hFFFFFF, 24'h000001, "R3 RJ16");
    wr(0, 8'h03);
    send_frame(24'hC0FFEE, 24'hBADA55, 24'h555555, 24'h666666, 2'b11, 24'h0A0B0C, 24'hD0E0F0, "R3 RJ24");
    // source B (R2)
    wr(1, 8'h01);
    send_frame(24'h999999, 24'hAAAAAA, 24'h1E2D3C, 24'h4B5A69, 2'b11, 24'h010203, 24'h040506, "R2 source B");
    // mid-frame write must wait for the next frame (R6)
    send_frame(24'h999999, 24'hAAAAAA, 24'h6A5B4C, 24'h3D2E1F, 2'b11, 24'h111213, 24'h141516,
               "R6 mid-frame write held", 32, 1'b1, 1'b0, 8'h00);
    send_frame(24'h999999, 24'hAAAAAA, 24'hE1D2C3, 24'hB4A596, 2'b00, 24'h212223, 24'h242526, "R6 new format");
    // back to A, then a short left slot (R8)
    wr(1, 8'h00);
    send_frame(24'h0BADF0, 24'h0D15EA, 24'h0, 24'h0, 2'b00, 24'h313233, 24'h343536, "R2 source A");
    send_frame(24'h765432, 24'h10FEDC, 24'h0, 24'h0, 2'b00, 24'h414243, 24'h444546, "R8 short slot", 30);
    send_frame(24'h246802, 24'h135791, 24'h0, 24'h0, 2'b00, 24'h515253, 24'h545556, "R8 recovered");
    // ADC format I2S (R10)
    wr(1, 8'h04);
    send_frame(24'h3C3C3C, 24'hC3C3C3, 24'h0, 24'h0, 2'b00, 24'hF00F00, 24'h0FF0FF, "R10 frame");
    // loopback with a format write held back (R4, R5, R7)
    wr(1, 8'h02);
    send_frame(24'h111111, 24'h222222, 24'h333333, 24'h444444, 2'b00, 24'hABC123, 24'h456DEF, "R4 loop first");
    wr(0, 8'h02);
    send_frame(24'h555555, 24'h666666, 24'h777777, 24'h888888, 2'b00, 24'h9E8D7C, 24'h6B5A49, "R4 loop second");
    wr(1, 8'h00);
    send_frame(24'hDEAD12, 24'hBEEF34, 24'h0, 24'h0, 2'b10, 24'h102030, 24'h405060, "R5 format at loop clear");
    send_frame(24'h4321AB, 24'h8765CD, 24'h0, 24'h0, 2'b10, 24'h708090, 24'hA0B0C0, "R5 format kept");
    // clocking change mutes the next pairs (R9)
    @(negedge clk); clk_chg = 1'b1;
    @(negedge clk); clk_chg = 1'b0;
    m_mute = MUTE_N;
    send_frame(24'h0A0A0A, 24'h0B0B0B, 24'h0, 24'h0, 2'b10, 24'h111000, 24'h222000, "R9 after mute a");
    send_frame(24'h0C0C0C, 24'h0D0D0D, 24'h0, 24'h0, 2'b10, 24'h333000, 24'h444000, "R9 after mute b");
    send_frame(24'h0E0E0E, 24'h0F0F0F, 24'h0, 24'h0, 2'b10, 24'h555000, 24'h666000, "R9 live again");
    boundary();
    sclk = 1'b0; lrck = 1'b0; tick(4);
    sclk = 1'b1; tick(14);
    chk(expq.size() == 0, "R8 one pair per frame", 64'(expq.size()), 64'(0));
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule